// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides who drives the external memory bus: the chip's own masters, or an outside master that asks for the bus through an active-low request pin. When release is enabled and the outside request is seen at a bus-cycle boundary, the block turns the chip's bus drivers off, waits one cycle, and then drops the acknowledge pin. The outside master then owns the bus until it raises its request pin again. The block then raises the acknowledge, waits one idle cycle, and turns the drivers back on.

While the bus is away, internal masters that need an external cycle, and refresh requests, are held off. When they are held off, an optional active-low request-out pin can ask the outside master to give the bus back. Once the bus is home, held requests are granted one at a time, refresh first. Three kinds of work compete for the bus in fixed priority: refresh, then outside release, then internal external access. Each internal or refresh grant lasts until the single cycle-done strobe ends it.

Top module: `bus_release_arb`

## Requirements
- R1: While `rel_en` is 0, a low `ext_req_n` never releases the bus: `ack_n` stays 1 and `bus_oe` stays 1.
- R2: `ext_req_n` passes through a two-flop synchronizer. A low level that is present before rising edge 1, with the block idle and owning the bus, turns `bus_oe` to 0 after edge 3 and `ack_n` to 0 after edge 4. `ack_n` is never 0 while `bus_oe` is 1.
- R3: An internal external access (`int_req`=1) made while the bus is released gets no `int_gnt`. `int_gnt` rises one edge after the bus is owned again, and any grant implies `bus_oe`=1.
- R4: A refresh request made while the bus is released is held off. After the bus is reclaimed, a held refresh is granted before a held internal access. The internal access is granted on the second edge after the refresh ends.
- R5: With `reqo_en`=1, a pending `int_req` or `rfsh_req` during release drives `reqo_n` to 0 on the next edge. It stays 0 until the same edge that restores `bus_oe`. With `reqo_en`=0, `reqo_n` stays 1.
- R6: After `ext_req_n` returns high, `ack_n` rises after edge 3 and `bus_oe` returns to 1 after edge 4.
- R7: There is exactly one cycle with `ack_n`=1 and `bus_oe`=0 between driver-off and acknowledge-low, and again between acknowledge-high and driver-on.
- R8: If an outside release and an internal access become eligible on the same edge, the release wins: `bus_oe` falls and `int_gnt` stays 0.
- R9: If a refresh and an outside release become eligible on the same edge, the refresh wins: `rfsh_gnt` rises and `bus_oe` stays 1.
- R10: An outside request is acted on only when no grant is outstanding. A grant holds until `cyc_done`=1 is sampled, and release starts one edge after the grant ends.
- R11: After reset, `ack_n`=1, `reqo_n`=1, `bus_oe`=1, and both grants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | Outside master bus request, active low, asynchronous |
| rel_en | input | 1 | Control bit: bus release allowed |
| reqo_en | input | 1 | Control bit: request-out pin enabled |
| int_req | input | 1 | Internal master wants an external cycle |
| rfsh_req | input | 1 | Refresh request |
| cyc_done | input | 1 | Current granted cycle finishes |
| ack_n | output | 1 | Bus acknowledge to outside master, active low |
| bus_oe | output | 1 | Enable for address, data and control drivers |
| int_gnt | output | 1 | Grant to the internal master |
| rfsh_gnt | output | 1 | Grant to refresh |
| reqo_n | output | 1 | Request to outside master to drop its request, active low |

## Verification
Two pairs of events can meet on one edge: a refresh request with an outside release, and an internal access with an outside release. The bench provokes each pair by lowering `ext_req_n` two cycles ahead. It then raises the competing request so that both are sampled on the third edge. A refresh must win with `bus_oe` still high. An internal access must lose, with drivers going off and no grant. A random phase then mixes all requests and done strobes, and checks the ordering and gap rules every cycle.

// File: rtl/bra_pkg.sv
package bra_pkg;
  typedef enum logic [1:0] {
    OWN_INT       = 2'd0,
    OWN_RELEASING = 2'd1,
    OWN_RELEASED  = 2'd2,
    OWN_RECLAIM   = 2'd3
  } own_state_t;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_INT  = 2'd1,
    CYC_RFSH = 2'd2
  } cyc_kind_t;
endpackage

// File: rtl/bra_sync.sv
module bra_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pin_n,
  output logic req_seen
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stg_d[i] = ~req_pin_n;
      end else begin : g_rest
        assign stg_d[i] = stg_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign req_seen = stg_q[STAGES-1];
endmodule

// File: rtl/bra_cycle_arb.sv
module bra_cycle_arb
  import bra_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_owned,
  input  logic ext_win,
  input  logic int_req,
  input  logic rfsh_req,
  input  logic cyc_done,
  output logic cyc_idle,
  output logic int_gnt,
  output logic rfsh_gnt
);
  cyc_kind_t cyc_q, cyc_d;
  logic      cyc_en;

  // Priority at a boundary: refresh, then outside release (no grant), then internal.
  always_comb begin
    cyc_d = cyc_q;
    case (cyc_q)
      CYC_IDLE: begin
        if (bus_owned) begin
          if (rfsh_req)                 cyc_d = CYC_RFSH;
          else if (!ext_win && int_req) cyc_d = CYC_INT;
        end
      end
      default: begin
        if (cyc_done) cyc_d = CYC_IDLE;
      end
    endcase
  end

  assign cyc_en = (cyc_d != cyc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= CYC_IDLE;
    else if (cyc_en) cyc_q <= cyc_d;
  end

  assign cyc_idle = (cyc_q == CYC_IDLE);
  assign int_gnt  = (cyc_q == CYC_INT);
  assign rfsh_gnt = (cyc_q == CYC_RFSH);
endmodule

// File: rtl/bra_own_fsm.sv
module bra_own_fsm
  import bra_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_req,
  input  logic       rel_en,
  input  logic       cyc_idle,
  input  logic       rfsh_req,
  output own_state_t st_q,
  output logic       ack_n,
  output logic       bus_oe
);
  own_state_t st_d;
  logic       st_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      OWN_INT:       if (cyc_idle && ext_req && rel_en && !rfsh_req) st_d = OWN_RELEASING;
      OWN_RELEASING: st_d = OWN_RELEASED;
      OWN_RELEASED:  if (!ext_req) st_d = OWN_RECLAIM;
      OWN_RECLAIM:   st_d = OWN_INT;
      default:       st_d = OWN_INT;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= OWN_INT;
    else if (st_en) st_q <= st_d;
  end

  assign ack_n  = (st_q != OWN_RELEASED);
  assign bus_oe = (st_q == OWN_INT);
endmodule

// File: rtl/bra_reqout.sv
module bra_reqout (
  input  logic clk,
  input  logic rst_n,
  input  logic reqo_en,
  input  logic in_release,
  input  logic pending,
  output logic reqo_n
);
  logic ask_q, ask_d;

  assign ask_d = reqo_en && in_release && (ask_q || pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ask_q <= 1'b0;
    else        ask_q <= ask_d;
  end

  assign reqo_n = ~ask_q;
endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb
  import bra_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_n,
  input  logic rel_en,
  input  logic reqo_en,
  input  logic int_req,
  input  logic rfsh_req,
  input  logic cyc_done,
  output logic ack_n,
  output logic bus_oe,
  output logic int_gnt,
  output logic rfsh_gnt,
  output logic reqo_n
);
  logic       ext_req;
  logic       cyc_idle;
  own_state_t own_st;

  bra_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_pin_n (ext_req_n),
    .req_seen  (ext_req)
  );

  bra_own_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_req  (ext_req),
    .rel_en   (rel_en),
    .cyc_idle (cyc_idle),
    .rfsh_req (rfsh_req),
    .st_q     (own_st),
    .ack_n    (ack_n),
    .bus_oe   (bus_oe)
  );

  bra_cycle_arb arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_owned (own_st == OWN_INT),
    .ext_win   (ext_req && rel_en),
    .int_req   (int_req),
    .rfsh_req  (rfsh_req),
    .cyc_done  (cyc_done),
    .cyc_idle  (cyc_idle),
    .int_gnt   (int_gnt),
    .rfsh_gnt  (rfsh_gnt)
  );

  bra_reqout rqo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqo_en    (reqo_en),
    .in_release (own_st == OWN_RELEASED),
    .pending    (int_req || rfsh_req),
    .reqo_n     (reqo_n)
  );
endmodule

// File: rtl/bra_chk.sv
module bra_chk (
  input logic clk,
  input logic rst_n,
  input logic rel_en,
  input logic reqo_en,
  input logic cyc_done,
  input logic ack_n,
  input logic bus_oe,
  input logic int_gnt,
  input logic rfsh_gnt,
  input logic reqo_n
);
  p_noen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(rel_en, 2));

  p_ack_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !bus_oe);

  p_gnt_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_gnt || rfsh_gnt) |-> bus_oe);

  p_reqo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reqo_en) |-> reqo_n);

  p_reqo_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reqo_n |-> !bus_oe);

  p_gap_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> !$past(bus_oe));

  p_gap_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(ack_n));

  p_gnt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_gnt && rfsh_gnt));

  p_hold_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_gnt && !cyc_done) |=> int_gnt);

  p_hold_rfsh_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_gnt && !cyc_done) |=> rfsh_gnt);
endmodule

bind bus_release_arb bra_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rel_en   (rel_en),
  .reqo_en  (reqo_en),
  .cyc_done (cyc_done),
  .ack_n    (ack_n),
  .bus_oe   (bus_oe),
  .int_gnt  (int_gnt),
  .rfsh_gnt (rfsh_gnt),
  .reqo_n   (reqo_n)
);

// File: tb/bus_release_arb_tb_top.sv
`timescale 1ns/1ps
module bus_release_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ext_req_n, rel_en, reqo_en, int_req, rfsh_req, cyc_done;
  logic ack_n, bus_oe, int_gnt, rfsh_gnt, reqo_n;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  bus_release_arb dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_req_n (ext_req_n),
    .rel_en    (rel_en),
    .reqo_en   (reqo_en),
    .int_req   (int_req),
    .rfsh_req  (rfsh_req),
    .cyc_done  (cyc_done),
    .ack_n     (ack_n),
    .bus_oe    (bus_oe),
    .int_gnt   (int_gnt),
    .rfsh_gnt  (rfsh_gnt),
    .reqo_n    (reqo_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Rules derived from the requirements
  function automatic bit rule_ack_hiz(logic a, logic o);
    return a || !o;
  endfunction
  function automatic bit rule_gnt_owned(logic ig, logic rg, logic o);
    return !(ig || rg) || o;
  endfunction
  function automatic bit rule_gap(logic pa, logic po, logic a, logic o);
    if (o && !po && !pa) return 1'b0;
    if (!a && pa && po)  return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    ext_req_n = 1'b1; rel_en = 1'b0; reqo_en = 1'b0;
    int_req = 1'b0; rfsh_req = 1'b0; cyc_done = 1'b0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R11 reset state
    chk("R11 ack_n", ack_n, 1);
    chk("R11 bus_oe", bus_oe, 1);
    chk("R11 reqo_n", reqo_n, 1);
    chk("R11 int_gnt", int_gnt, 0);
    chk("R11 rfsh_gnt", rfsh_gnt, 0);

    // R1 release disabled
    ext_req_n = 1'b0;
    tick(8);
    chk("R1 ack_n", ack_n, 1);
    chk("R1 bus_oe", bus_oe, 1);
    ext_req_n = 1'b1;
    tick(4);

    // R2 / R7 release timing
    rel_en = 1'b1;
    ext_req_n = 1'b0;
    tick(2);
    chk("R2 oe before edge3", bus_oe, 1);
    tick(1);
    chk("R7 gap oe off", bus_oe, 0);
    chk("R7 gap ack high", ack_n, 1);
    tick(1);
    chk("R2 ack low", ack_n, 0);

    // R3 / R5 deferral with request-out
    reqo_en = 1'b1;
    int_req = 1'b1;
    tick(1);
    chk("R5 reqo low", reqo_n, 0);
    chk("R3 no grant", int_gnt, 0);
    tick(5);
    chk("R3 still held", int_gnt, 0);
    ext_req_n = 1'b1;
    tick(3);
    chk("R6 ack high", ack_n, 1);
    chk("R7 gap oe still off", bus_oe, 0);
    chk("R5 reqo held", reqo_n, 0);
    tick(1);
    chk("R6 oe on", bus_oe, 1);
    chk("R5 reqo released", reqo_n, 1);
    chk("R3 grant not yet", int_gnt, 0);
    tick(1);
    chk("R3 grant after reclaim", int_gnt, 1);
    cyc_done = 1'b1; int_req = 1'b0;
    tick(1);
    cyc_done = 1'b0;

    // R4 order after reclaim, R5 disabled
    reqo_en = 1'b0;
    ext_req_n = 1'b0;
    tick(4);
    chk("R4 released", ack_n, 0);
    rfsh_req = 1'b1; int_req = 1'b1;
    tick(3);
    chk("R5 disabled stays high", reqo_n, 1);
    chk("R4 refresh held", rfsh_gnt, 0);
    ext_req_n = 1'b1;
    tick(5);
    chk("R4 refresh first", rfsh_gnt, 1);
    chk("R4 internal waits", int_gnt, 0);
    cyc_done = 1'b1; rfsh_req = 1'b0;
    tick(1);
    cyc_done = 1'b0;
    chk("R4 refresh ended", rfsh_gnt, 0);
    tick(1);
    chk("R4 internal next", int_gnt, 1);
    cyc_done = 1'b1; int_req = 1'b0;
    tick(1);
    cyc_done = 1'b0;

    // R9 refresh beats release on the same edge
    ext_req_n = 1'b0;
    tick(2);
    rfsh_req = 1'b1;
    tick(1);
    chk("R9 refresh granted", rfsh_gnt, 1);
    chk("R9 bus kept", bus_oe, 1);
    tick(3);
    chk("R10 hold during refresh", bus_oe, 1);
    chk("R10 ack high during refresh", ack_n, 1);
    cyc_done = 1'b1; rfsh_req = 1'b0;
    tick(1);
    cyc_done = 1'b0;
    chk("R10 oe at boundary", bus_oe, 1);
    tick(1);
    chk("R10 release after refresh", bus_oe, 0);
    tick(1);
    chk("R9 ack low after refresh", ack_n, 0);
    ext_req_n = 1'b1;
    tick(4);
    chk("R6 back home", bus_oe, 1);

    // R8 release beats internal on the same edge
    ext_req_n = 1'b0;
    tick(2);
    int_req = 1'b1;
    tick(1);
    chk("R8 no internal grant", int_gnt, 0);
    chk("R8 drivers off", bus_oe, 0);
    tick(1);
    chk("R8 ack low", ack_n, 0);
    ext_req_n = 1'b1;
    tick(5);
    chk("R3 internal after R8", int_gnt, 1);
    cyc_done = 1'b1; int_req = 1'b0;
    tick(1);
    cyc_done = 1'b0;

    // R10 request during an internal cycle waits for done
    int_req = 1'b1;
    tick(1);
    chk("R10 internal granted", int_gnt, 1);
    ext_req_n = 1'b0;
    tick(6);
    chk("R10 grant held", int_gnt, 1);
    chk("R10 bus held", bus_oe, 1);
    chk("R10 ack held", ack_n, 1);
    cyc_done = 1'b1; int_req = 1'b0;
    tick(1);
    cyc_done = 1'b0;
    chk("R10 grant ended", int_gnt, 0);
    chk("R10 oe at end", bus_oe, 1);
    tick(1);
    chk("R10 release follows", bus_oe, 0);
    tick(1);
    chk("R2 ack after boundary", ack_n, 0);
    ext_req_n = 1'b1;
    tick(4);

    // Random phase
    void'($urandom(32'd20240611));
    rel_en = 1'b0;
    reqo_en = 1'b1;
    begin
      logic pa, po;
      pa = ack_n; po = bus_oe;
      for (int c = 0; c < 4000; c++) begin
        @(negedge clk);
        chk("R2 ack low implies hiz", rule_ack_hiz(ack_n, bus_oe), 1);
        chk("R3 grant implies owned", rule_gnt_owned(int_gnt, rfsh_gnt, bus_oe), 1);
        chk("R7 idle gap", rule_gap(pa, po, ack_n, bus_oe), 1);
        chk("R9 single grant", int_gnt && rfsh_gnt, 0);
        chk("R5 reqo only in release", !reqo_n && bus_oe, 0);
        if (c < 400) chk("R1 disabled random", ack_n, 1);
        pa = ack_n; po = bus_oe;
        if (c == 400) rel_en = 1'b1;
        cyc_done = 1'b0;
        if (int_gnt || rfsh_gnt) begin
          if ($urandom % 3 == 0) begin
            cyc_done = 1'b1;
            if (int_gnt) int_req = 1'b0;
            else         rfsh_req = 1'b0;
          end
        end
        if (!int_req && $urandom % 10 == 0)  int_req = 1'b1;
        if (!rfsh_req && $urandom % 30 == 0) rfsh_req = 1'b1;
        if ($urandom % 16 == 0) ext_req_n = ~ext_req_n;
      end
    end

    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule